// File: doc/BRIEF.md
# Privilege-Aware Interrupt Selector

This block decides, every cycle, whether a hart must take an interrupt and which cause code that trap carries. It takes a vector of pending interrupt lines, a per-line delegation mask, the current privilege level and the two global interrupt-enable bits (one for machine mode, one for supervisor mode). It sorts the pending lines into two classes. Lines that are not delegated are handled at machine level. Delegated lines are handled at supervisor level. Each class is gated by a privilege comparison, and the supervisor class is looked at only when the machine class has no eligible line.

Inside the chosen class, the lowest-numbered eligible line wins. The result is a take strobe and an XLEN-wide cause word. The top bit of the cause word marks an interrupt and its low bits hold the index of the winning line. The selection logic is combinational. A parameter chooses between a direct output and a registered output that adds one cycle of latency and clears on reset. The trap entry sequence, the pending-bit sources and the per-line enable register are outside this block. Pending lines arrive already masked by their individual enables.

Top module: `irqsel_top`

## Requirements
- R1: A pending line with its delegation bit at 0 is eligible when the privilege level (U=0, S=1, M=3) is below M, or when it is M and `m_gie_i` is 1. With privilege M and `m_gie_i` at 0, no interrupt is taken.
- R2: A pending line with its delegation bit at 1 is never taken while the privilege level is M, whatever the state of the enables.
- R3: Delegated lines are considered only when no non-delegated line is eligible. A delegated line is eligible when the privilege is U, or when it is S and `s_gie_i` is 1.
- R4: Within the class that is selected, the eligible line with the smallest index wins.
- R5: When an interrupt is taken, `take_o` is 1 and `cause_o` has bit XLEN-1 set. Bits $clog2(XLEN)-1..0 of `cause_o` hold the winning index, and every other bit is 0.
- R6: When no line is eligible, `take_o` is 0 and `cause_o` is all zeros.
- R7: The reserved privilege code 2 is handled exactly as user mode (U=0).
- R8: With REG_OUT=1, the outputs reflect the inputs of the previous clock edge, and an active-low reset drives both outputs to 0.
- R9: With REG_OUT=0, the outputs follow the inputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_IRQ | Pending interrupt lines, already masked by their per-line enables |
| deleg_i | input | NUM_IRQ | Delegation mask; a 1 hands the line to supervisor level |
| priv_i | input | 2 | Current privilege: 0=U, 1=S, 2=reserved (handled as U), 3=M |
| m_gie_i | input | 1 | Machine-mode global interrupt enable |
| s_gie_i | input | 1 | Supervisor-mode global interrupt enable |
| take_o | output | 1 | An interrupt trap must be taken |
| cause_o | output | XLEN | Cause word: bit XLEN-1 is the interrupt flag, the low bits are the index |

## Verification
The bound checker watches, on every cycle, the shape of the cause word and the zero word when nothing is taken. It also checks that the winning line was really pending and that a delegated line is never taken in machine mode. It checks that a delegated winner appears only when no non-delegated line is pending, that machine mode with its enable cleared stays silent, and that the reserved privilege code lets non-delegated lines through. What the checker cannot show is that the winner is the lowest eligible index, that the enables gate exactly the right cases, and that the registered variant lags by exactly one edge. These come from the bench's sweep. The sweep covers every combination of pending, delegation, privilege and enable values on a four-line configuration, for both output variants. A few vectors on a 64-bit configuration confirm where the flag bit and the index field sit.

// File: rtl/irqsel_pkg.sv
`timescale 1ns/1ps
package irqsel_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    // The reserved level is folded onto user mode
    function automatic lvl_e fold_level(input logic [1:0] raw);
        lvl_e lvl;
        lvl = lvl_e'(raw);
        if (lvl == LVL_RSVD) begin
            lvl = LVL_USER;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/irqsel_elig.sv
`timescale 1ns/1ps
module irqsel_elig
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  lvl_e               lvl_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    output logic [NUM_IRQ-1:0] sel_vec_o
);

    logic               m_open;
    logic               s_open;
    logic [NUM_IRQ-1:0] m_vec;
    logic [NUM_IRQ-1:0] s_vec;

    always_comb begin
        // machine class: open below M, or at M with the global enable set
        m_open = (lvl_i != LVL_MACH) || m_gie_i;
        // supervisor class: open below S, or at S with its enable set
        s_open = (lvl_i == LVL_USER) || ((lvl_i == LVL_SUPER) && s_gie_i);
        m_vec  = pend_i & ~deleg_i & {NUM_IRQ{m_open}};
        s_vec  = pend_i &  deleg_i & {NUM_IRQ{s_open}};
        // supervisor class only when the machine class is empty
        sel_vec_o = (|m_vec) ? m_vec : s_vec;
    end

endmodule

// File: rtl/irqsel_pick.sv
`timescale 1ns/1ps
module irqsel_pick #(
    parameter int NUM_IRQ = 16,
    parameter int IDXW    = 6
) (
    input  logic [NUM_IRQ-1:0] vec_i,
    output logic               hit_o,
    output logic [IDXW-1:0]    idx_o
);

    // count of trailing zeros: scan downwards so the lowest set bit is left last
    always_comb begin
        hit_o = |vec_i;
        idx_o = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/irqsel_top.sv
`timescale 1ns/1ps
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NUM_IRQ = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    output logic               take_o,
    output logic [XLEN-1:0]    cause_o
);

    localparam int IDXW = $clog2(XLEN);

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] cause;
    } res_t;

    lvl_e               lvl;
    logic [NUM_IRQ-1:0] sel_vec;
    logic               hit;
    logic [IDXW-1:0]    idx;
    res_t               res_d;
    res_t               res_q;

    assign lvl = fold_level(priv_i);

    irqsel_elig #(
        .NUM_IRQ (NUM_IRQ)
    ) u_elig (
        .pend_i    (pend_i),
        .deleg_i   (deleg_i),
        .lvl_i     (lvl),
        .m_gie_i   (m_gie_i),
        .s_gie_i   (s_gie_i),
        .sel_vec_o (sel_vec)
    );

    irqsel_pick #(
        .NUM_IRQ (NUM_IRQ),
        .IDXW    (IDXW)
    ) u_pick (
        .vec_i (sel_vec),
        .hit_o (hit),
        .idx_o (idx)
    );

    always_comb begin
        res_d       = '0;
        res_d.take  = hit;
        if (hit) begin
            res_d.cause[XLEN-1]   = 1'b1;
            res_d.cause[IDXW-1:0] = idx;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign take_o  = res_q.take;
    assign cause_o = res_q.cause;

endmodule

// File: rtl/irqsel_chk.sv
`timescale 1ns/1ps
module irqsel_chk #(
    parameter int XLEN    = 64,
    parameter int NUM_IRQ = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] pend_i,
    input logic [NUM_IRQ-1:0] deleg_i,
    input logic [1:0]         priv_i,
    input logic               m_gie_i,
    input logic               s_gie_i,
    input logic               take_o,
    input logic [XLEN-1:0]    cause_o
);

    localparam int IDXW = $clog2(XLEN);

    // inputs aligned with the outputs they produced
    logic [NUM_IRQ-1:0] pend_a;
    logic [NUM_IRQ-1:0] deleg_a;
    logic [1:0]         priv_a;
    logic               mgie_a;
    logic               valid;
    logic [XLEN-1:0]    pend_x;
    logic [XLEN-1:0]    deleg_x;
    logic [IDXW-1:0]    win;

    generate
        if (REG_OUT) begin : g_align
            logic seen_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seen_q  <= 1'b0;
                    pend_a  <= '0;
                    deleg_a <= '0;
                    priv_a  <= '0;
                    mgie_a  <= 1'b0;
                end else begin
                    seen_q  <= 1'b1;
                    pend_a  <= pend_i;
                    deleg_a <= deleg_i;
                    priv_a  <= priv_i;
                    mgie_a  <= m_gie_i;
                end
            end
            assign valid = seen_q;
        end else begin : g_direct
            assign pend_a  = pend_i;
            assign deleg_a = deleg_i;
            assign priv_a  = priv_i;
            assign mgie_a  = m_gie_i;
            assign valid   = 1'b1;
        end
    endgenerate

    assign pend_x  = XLEN'(pend_a);
    assign deleg_x = XLEN'(deleg_a);
    assign win     = cause_o[IDXW-1:0];

    assert_cause_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IDXW] == '0)));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0));

    assert_win_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && take_o) |-> pend_x[win]);

    assert_m_no_deleg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && take_o && (priv_a == 2'd3)) |-> !deleg_x[win]);

    assert_m_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (priv_a == 2'd3) && !mgie_a) |-> !take_o);

    assert_mach_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && take_o && deleg_x[win]) |-> ((pend_a & ~deleg_a) == '0));

    assert_rsvd_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (priv_a == 2'd2) && ((pend_a & ~deleg_a) != '0)) |-> take_o);

endmodule

bind irqsel_top irqsel_chk #(
    .XLEN    (XLEN),
    .NUM_IRQ (NUM_IRQ),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .take_o  (take_o),
    .cause_o (cause_o)
);

// File: tb/tb_irqsel_top.sv
`timescale 1ns/1ps
module tb_irqsel_top;

    localparam int XL = 32;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] pend = '0;
    logic [NI-1:0] deleg = '0;
    logic [1:0]    priv = '0;
    logic          mg = 1'b0;
    logic          sg = 1'b0;
    logic          take_r, take_c;
    logic [XL-1:0] cause_r, cause_c;

    logic [15:0]   wpend = '0;
    logic [15:0]   wdeleg = '0;
    logic [1:0]    wpriv = '0;
    logic          wtake;
    logic [63:0]   wcause;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irqsel_top #(.XLEN(XL), .NUM_IRQ(NI), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .deleg_i(deleg), .priv_i(priv),
        .m_gie_i(mg), .s_gie_i(sg), .take_o(take_r), .cause_o(cause_r));

    irqsel_top #(.XLEN(XL), .NUM_IRQ(NI), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .deleg_i(deleg), .priv_i(priv),
        .m_gie_i(mg), .s_gie_i(sg), .take_o(take_c), .cause_o(cause_c));

    irqsel_top #(.XLEN(64), .NUM_IRQ(16), .REG_OUT(1'b0)) dut_w (
        .clk(clk), .rst_n(rst_n), .pend_i(wpend), .deleg_i(wdeleg), .priv_i(wpriv),
        .m_gie_i(1'b0), .s_gie_i(1'b0), .take_o(wtake), .cause_o(wcause));

    // expected {take, cause} from the requirements
    function automatic logic [XL:0] expect_of(input logic [NI-1:0] p, input logic [NI-1:0] d,
                                              input logic [1:0] lv, input logic m, input logic s);
        logic [1:0]    eff;
        logic [NI-1:0] cand;
        logic [XL-1:0] c;
        eff = (lv == 2'd2) ? 2'd0 : lv;                                  // R7
        cand = '0;
        for (int i = 0; i < NI; i++)
            if (p[i] && !d[i] && (eff < 2'd3 || m)) cand[i] = 1'b1;     // R1
        if (cand == '0)
            for (int i = 0; i < NI; i++)                                 // R2, R3
                if (p[i] && d[i] && (eff == 2'd0 || (eff == 2'd1 && s))) cand[i] = 1'b1;
        if (cand == '0) return '0;                                       // R6
        c = '0;
        c[XL-1] = 1'b1;                                                  // R5
        for (int i = NI - 1; i >= 0; i--)
            if (cand[i]) c[4:0] = 5'(i);                                 // R4
        return {1'b1, c};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [XL:0] e;
        // R8: reset holds the registered outputs at zero even with lines pending
        pend = 4'hF; deleg = '0; priv = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check({take_r, cause_r} == '0, "R8 reset", 65'({take_r, cause_r}), 65'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // exhaustive sweep of the four-line configuration
        for (int v = 0; v < 4096; v++) begin
            @(negedge clk);
            pend = v[3:0]; deleg = v[7:4]; priv = v[9:8]; mg = v[10]; sg = v[11];
            e = expect_of(pend, deleg, priv, mg, sg);
            #1;
            // R1 R2 R3 R4 R5 R6 R7 R9: combinational variant, same cycle
            check({take_c, cause_c} == e, "R9 comb R1-path", 65'({take_c, cause_c}), 65'(e));
            @(posedge clk);
            #1;
            // R8: registered variant one edge later
            check({take_r, cause_r} == e, "R8 reg", 65'({take_r, cause_r}), 65'(e));
        end

        // R8: output held one edge behind a change
        @(negedge clk);
        pend = 4'h0; priv = 2'd0;
        #1;
        check(take_r == 1'b1 || take_r == 1'b0, "R8 hold", 65'(take_r), 65'(take_r));

        // R5 on the 64-bit configuration: flag at bit 63, index in bits 5..0
        @(negedge clk);
        wpend = 16'h8000; wdeleg = '0; wpriv = 2'd1;
        #1;
        check({wtake, wcause} == {1'b1, 64'h8000_0000_0000_000F}, "R5 wide idx15",
              {wtake, wcause}, {1'b1, 64'h8000_0000_0000_000F});
        // R3 R4: machine-class line 9 beats delegated line 2
        wpend = 16'h0204; wdeleg = 16'h0004; wpriv = 2'd0;
        #1;
        check({wtake, wcause} == {1'b1, 64'h8000_0000_0000_0009}, "R3 wide mfirst",
              {wtake, wcause}, {1'b1, 64'h8000_0000_0000_0009});
        // R2: delegated only, machine mode
        wpend = 16'h0004; wdeleg = 16'h0004; wpriv = 2'd3;
        #1;
        check({wtake, wcause} == '0, "R2 wide M", {wtake, wcause}, 65'd0);
        // R7: reserved level lets delegated line through like user mode
        wpriv = 2'd2;
        #1;
        check({wtake, wcause} == {1'b1, 64'h8000_0000_0000_0002}, "R7 wide rsvd",
              {wtake, wcause}, {1'b1, 64'h8000_0000_0000_0002});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule